// File: doc/BRIEF.md
# Cipher Unit FIFO Error Monitor

This block is the host-side control shell that sits around the data FIFOs of a block-cipher engine. The host writes 64-bit words into an input FIFO and reads results from an output FIFO. Between the two sits a stand-in for the cipher datapath: a fixed-latency stage that passes each word through unchanged. The block watches both FIFOs and its own register space for misuse. It latches each fault in a status register and raises one interrupt line. Each fault can be masked.

A job begins when the host writes a word count to the size register. The engine then consumes input words as they arrive, but it always keeps the newest word back in the input FIFO. That held word is released only when the host writes the end-of-message register. The engine then drains what is left, waits for the datapath to empty, and latches a done flag.

The engine controller is a four-state machine:
- **IDLE**: waits for a size write, then moves to STREAM.
- **STREAM**: pops only while more than one word is held and words remain to be counted. An end-of-message write moves it to FINISH.
- **FINISH**: pops on every cycle until the count reaches zero, even from an empty FIFO. It then moves to FLUSH.
- **FLUSH**: waits until the datapath is empty, pulses done, and returns to IDLE.

Top module: `cipher_fifo_monitor`

Register offsets (word address on `reg_addr`):

| Offset | Register | Access |
|---|---|---|
| 0 | data-in | write pushes a word |
| 1 | data-out | read pops a word |
| 2 | size | write loads the count; read returns the remaining count |
| 3 | end-of-message | write only; reads as zero |
| 4 | status | read; write-one-to-clear |
| 5 | mask | read/write |

Status bit positions (the mask register uses the same positions for bits 57 to 63):

| Bit | Meaning |
|---|---|
| 56 | done |
| 57 | output FIFO not empty at a size write |
| 58 | output FIFO underflow |
| 59 | output FIFO overflow |
| 60 | input FIFO overflow |
| 61 | input FIFO not empty at done |
| 62 | input FIFO underflow |
| 63 | address error |

## Requirements
- R1: After reset the status register, the mask register, `reg_rdata` and `irq` are all zero.
- R2: Words written to offset 0 come out of offset 1 unchanged and in the same order. Read data appears on `reg_rdata` one cycle after the read strobe.
- R3: With a size of N and N words pushed, the engine processes only N-1 words before end-of-message. A read of offset 2 then returns 1, and done (bit 56) stays clear.
- R4: A write of any value to offset 3 makes the engine process the held word and then set status bit 56. A read of offset 3 returns zero.
- R5: A push to a full input FIFO (32 words by default) sets bit 60 and the word is dropped. Stored contents and order are not changed.
- R6: If the engine pops the input FIFO while it is empty (count larger than the words supplied), bit 62 is set and a zero word enters the datapath.
- R7: A datapath result arriving at a full output FIFO sets bit 59 and that result is dropped. Earlier results keep their order.
- R8: A read of offset 1 while the output FIFO is empty returns zero and sets bit 58.
- R9: If the input FIFO still holds data when done is raised, bit 61 is set.
- R10: A write to offset 2 while the output FIFO holds data sets bit 57.
- R11: Each of these sets bit 63: any access to offsets 6 or 7, a read of offset 0, and a write of offset 1.
- R12: `irq` is the OR of bit 56 and every latched error bit whose mask bit (same position, offset 5) is 0. A mask bit of 1 blocks that error from `irq`, but its status bit is still latched.
- R13: A write to offset 4 clears exactly the status bits written as 1 and leaves the others set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, valid the cycle after `reg_rd` |
| irq | output | 1 | Interrupt: done or any unmasked latched error |

## Verification
The bench keeps the input FIFO at its default depth of 32 and sets the datapath latency to 2. It shrinks the output FIFO to 4 entries. With this setup, one 33-word burst overflows the input FIFO. A single 33-count job run on that burst then overflows the output FIFO and also underflows the input FIFO. The small output depth also makes the output overflow and the output-not-empty-at-size-write condition cheap to reach.

// File: rtl/cfm_pkg.sv
package cfm_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 64;

    localparam logic [ADDR_W-1:0] OFS_DIN  = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_DOUT = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_SIZE = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_EOM  = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_STAT = 3'd4;
    localparam logic [ADDR_W-1:0] OFS_MASK = 3'd5;

    // status field: index k maps to register bit STAT_LSB + k
    localparam int STAT_LSB = 56;
    localparam int STAT_W   = 8;
    localparam int S_DONE = 0;
    localparam int S_ONE  = 1;
    localparam int S_OUNF = 2;
    localparam int S_OOVF = 3;
    localparam int S_IOVF = 4;
    localparam int S_INE  = 5;
    localparam int S_IUNF = 6;
    localparam int S_ADR  = 7;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STREAM = 2'd1,
        ST_FINISH = 2'd2,
        ST_FLUSH  = 2'd3
    } eng_state_e;
endpackage

// File: rtl/cfm_fifo.sv
module cfm_fifo #(
    parameter int W     = 64,
    parameter int DEPTH = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         ovf,
    output logic                         unf
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH-1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic             do_push, do_pop, not_empty;

    assign not_empty = (count != '0);
    assign do_pop    = pop && not_empty;
    assign do_push   = push && ((count != FULL_CNT) || do_pop);
    assign ovf       = push && !do_push;
    assign unf       = pop && !do_pop;
    assign dout      = not_empty ? mem[rp] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= (wp == LAST_PTR) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == LAST_PTR) ? '0 : rp + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT); // R5
    AST_OVF_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && count == FULL_CNT) |=> (count == FULL_CNT)); // R5
    AST_UNF_GIVES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && count == '0) |-> (dout == '0)); // R8
endmodule

// File: rtl/cfm_pipe.sv
module cfm_pipe #(
    parameter int W   = 64,
    parameter int LAT = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_vld,
    input  logic [W-1:0] in_dat,
    output logic         out_vld,
    output logic [W-1:0] out_dat,
    output logic         busy
);
    logic [LAT-1:0] vld;
    logic [W-1:0]   dat [LAT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld[0] <= 1'b0;
        else        vld[0] <= in_vld;
    end

    always_ff @(posedge clk) begin
        dat[0] <= in_dat;
    end

    for (genvar i = 1; i < LAT; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) vld[i] <= 1'b0;
            else        vld[i] <= vld[i-1];
        end
        always_ff @(posedge clk) begin
            dat[i] <= dat[i-1];
        end
    end

    assign out_vld = vld[LAT-1];
    assign out_dat = dat[LAT-1];
    assign busy    = |vld;
endmodule

// File: rtl/cfm_ctrl.sv
module cfm_ctrl
    import cfm_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ICNT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              size_wr,
    input  logic [CNT_W-1:0]  size_val,
    input  logic              eom_wr,
    input  logic [ICNT_W-1:0] in_count,
    input  logic              pipe_busy,
    output logic              in_pop,
    output logic              done_pulse,
    output logic              final_phase,
    output logic [CNT_W-1:0]  remaining
);
    eng_state_e state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt        = state;
        in_pop     = 1'b0;
        done_pulse = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (size_wr) nxt = ST_STREAM;
            end
            ST_STREAM: begin
                in_pop = (remaining != '0) && (in_count > ICNT_W'(1));
                if (eom_wr) nxt = ST_FINISH;
            end
            ST_FINISH: begin
                in_pop = (remaining != '0);
                if (remaining == '0) nxt = ST_FLUSH;
            end
            ST_FLUSH: begin
                if (!pipe_busy) begin
                    done_pulse = 1'b1;
                    nxt        = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          remaining <= '0;
        else if (state == ST_IDLE && size_wr) remaining <= size_val;
        else if (in_pop)                     remaining <= remaining - 1'b1;
    end

    assign final_phase = (state == ST_FINISH);

    AST_DONE_AFTER_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> (remaining == '0)); // R4
    AST_DONE_NO_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> !pipe_busy); // R4
endmodule

// File: rtl/cipher_fifo_monitor.sv
module cipher_fifo_monitor
    import cfm_pkg::*;
#(
    parameter int IN_DEPTH  = 32,
    parameter int OUT_DEPTH = 32,
    parameter int LAT       = 2,
    parameter int CNT_W     = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               irq
);
    localparam int ICNT_W = $clog2(IN_DEPTH+1);
    localparam int OCNT_W = $clog2(OUT_DEPTH+1);
    localparam int MSK_W  = STAT_W - 1;

    logic wr_din, wr_size, wr_eom, wr_stat, wr_mask, rd_dout, bad_addr;
    logic [DATA_W-1:0] in_dout, out_dout, pipe_dat;
    logic [ICNT_W-1:0] in_count;
    logic [OCNT_W-1:0] out_count;
    logic in_ovf, in_unf, out_ovf, out_unf;
    logic in_pop, done_pulse, final_phase, pipe_vld, pipe_busy;
    logic [CNT_W-1:0]  remaining;
    logic [STAT_W-1:0] st, set_v, clr_v;
    logic [MSK_W-1:0]  mask_q;

    assign wr_din   = reg_wr && (reg_addr == OFS_DIN);
    assign wr_size  = reg_wr && (reg_addr == OFS_SIZE);
    assign wr_eom   = reg_wr && (reg_addr == OFS_EOM);
    assign wr_stat  = reg_wr && (reg_addr == OFS_STAT);
    assign wr_mask  = reg_wr && (reg_addr == OFS_MASK);
    assign rd_dout  = reg_rd && (reg_addr == OFS_DOUT);
    assign bad_addr = (reg_wr && (reg_addr == OFS_DOUT || reg_addr > OFS_MASK))
                   || (reg_rd && (reg_addr == OFS_DIN  || reg_addr > OFS_MASK));

    cfm_fifo #(.W(DATA_W), .DEPTH(IN_DEPTH)) u_in_fifo (
        .clk(clk), .rst_n(rst_n), .push(wr_din), .din(reg_wdata),
        .pop(in_pop), .dout(in_dout), .count(in_count), .ovf(in_ovf), .unf(in_unf)
    );

    cfm_pipe #(.W(DATA_W), .LAT(LAT)) u_pipe (
        .clk(clk), .rst_n(rst_n), .in_vld(in_pop), .in_dat(in_dout),
        .out_vld(pipe_vld), .out_dat(pipe_dat), .busy(pipe_busy)
    );

    cfm_fifo #(.W(DATA_W), .DEPTH(OUT_DEPTH)) u_out_fifo (
        .clk(clk), .rst_n(rst_n), .push(pipe_vld), .din(pipe_dat),
        .pop(rd_dout), .dout(out_dout), .count(out_count), .ovf(out_ovf), .unf(out_unf)
    );

    cfm_ctrl #(.CNT_W(CNT_W), .ICNT_W(ICNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .size_wr(wr_size), .size_val(reg_wdata[CNT_W-1:0]),
        .eom_wr(wr_eom), .in_count(in_count), .pipe_busy(pipe_busy),
        .in_pop(in_pop), .done_pulse(done_pulse), .final_phase(final_phase),
        .remaining(remaining)
    );

    always_comb begin
        set_v         = '0;
        set_v[S_DONE] = done_pulse;
        set_v[S_ONE]  = wr_size && (out_count != '0);
        set_v[S_OUNF] = out_unf;
        set_v[S_OOVF] = out_ovf;
        set_v[S_IOVF] = in_ovf;
        set_v[S_INE]  = done_pulse && (in_count != '0);
        set_v[S_IUNF] = in_unf;
        set_v[S_ADR]  = bad_addr;
        clr_v = wr_stat ? reg_wdata[DATA_W-1:STAT_LSB] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= '0;
            mask_q <= '0;
        end else begin
            st <= (st & ~clr_v) | set_v;
            if (wr_mask) mask_q <= reg_wdata[DATA_W-1:STAT_LSB+1];
        end
    end

    assign irq = st[S_DONE] | (|(st[STAT_W-1:1] & ~mask_q));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            unique case (reg_addr)
                OFS_DOUT: reg_rdata <= out_dout;
                OFS_SIZE: reg_rdata <= {{(DATA_W-CNT_W){1'b0}}, remaining};
                OFS_STAT: reg_rdata <= {st, {STAT_LSB{1'b0}}};
                OFS_MASK: reg_rdata <= {mask_q, {(STAT_LSB+1){1'b0}}};
                default:  reg_rdata <= '0;
            endcase
        end
    end

    AST_HOLD_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (in_pop && !final_phase) |-> (in_count > ICNT_W'(1))); // R3
    AST_EOM_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_wr && reg_addr == OFS_EOM) |=> (reg_rdata == '0)); // R4
    AST_IOVF_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        in_ovf |=> st[S_IOVF]); // R5
    AST_ADDR_ERR_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr > OFS_MASK) |=> st[S_ADR]); // R11
    AST_OUNF_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        out_unf |=> st[S_OUNF]); // R8
endmodule

// File: tb/test_cipher_fifo_monitor.sv
module test_cipher_fifo_monitor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    localparam logic [2:0] A_DIN = 3'd0, A_DOUT = 3'd1, A_SIZE = 3'd2,
                           A_EOM = 3'd3, A_STAT = 3'd4, A_MASK = 3'd5;
    localparam logic [63:0] B_DONE = 64'h1 << 56, B_ONE = 64'h1 << 57,
                            B_OUNF = 64'h1 << 58, B_OOVF = 64'h1 << 59,
                            B_IOVF = 64'h1 << 60, B_INE = 64'h1 << 61,
                            B_IUNF = 64'h1 << 62, B_ADR = 64'h1 << 63;

    always #2.5 clk = ~clk;

    cipher_fifo_monitor #(.IN_DEPTH(32), .OUT_DEPTH(4), .LAT(2), .CNT_W(16)) i_cipher_fifo_monitor (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    typedef struct packed {
        logic        wr;
        logic [2:0]  a;
        logic [63:0] d;
        logic [63:0] exp;
        logic [7:0]  req;
    } vec_t;

    // basic job: R2 ordering, R3 hold-back, R4 end-of-message, R13 clear
    localparam vec_t VEC [14] = '{
        '{1'b1, A_SIZE, 64'd3,                  64'd0,          8'd2},  // R2
        '{1'b1, A_DIN,  64'hA5A5_0000_0000_0001, 64'd0,         8'd2},
        '{1'b1, A_DIN,  64'hA5A5_0000_0000_0002, 64'd0,         8'd2},
        '{1'b1, A_DIN,  64'hA5A5_0000_0000_0003, 64'd0,         8'd2},
        '{1'b0, A_SIZE, 64'd0,                  64'd1,          8'd3},  // R3
        '{1'b0, A_DOUT, 64'd0, 64'hA5A5_0000_0000_0001,          8'd2},
        '{1'b0, A_DOUT, 64'd0, 64'hA5A5_0000_0000_0002,          8'd2},
        '{1'b0, A_STAT, 64'd0,                  64'd0,          8'd3},  // R3
        '{1'b1, A_EOM,  64'hDEAD_BEEF_0BAD_F00D, 64'd0,         8'd4},  // R4
        '{1'b0, A_EOM,  64'd0,                  64'd0,          8'd4},
        '{1'b0, A_STAT, 64'd0,                  B_DONE,         8'd4},
        '{1'b0, A_DOUT, 64'd0, 64'hA5A5_0000_0000_0003,          8'd2},
        '{1'b1, A_STAT, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0,         8'd13}, // R13
        '{1'b0, A_STAT, 64'd0,                  64'd0,          8'd13}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic op(input logic w, input logic [2:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_wr = w; reg_rd = !w; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] a, input logic [63:0] exp, input string req);
        op(1'b0, a, 64'd0);
        chk(req, reg_rdata, exp);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(5ns * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state
        chk("R1 irq", {63'd0, irq}, 64'd0);
        chk("R1 rdata", reg_rdata, 64'd0);
        rd(A_STAT, 64'd0, "R1 status");
        rd(A_MASK, 64'd0, "R1 mask");

        for (int i = 0; i < 14; i++) begin
            op(VEC[i].wr, VEC[i].a, VEC[i].d);
            if (!VEC[i].wr)
                chk($sformatf("R%0d vec%0d", VEC[i].req, i), reg_rdata, VEC[i].exp);
            idle(10);
        end
        chk("R13 irq after clear", {63'd0, irq}, 64'd0);

        // R5 input overflow: 33 pushes while idle, last one dropped
        for (int i = 0; i < 33; i++) op(1'b1, A_DIN, 64'h100 + 64'(i));
        rd(A_STAT, B_IOVF, "R5 overflow flag");
        // R6/R7: job of 33 words on 32 stored -> one empty pop, output overflow
        op(1'b1, A_SIZE, 64'd33);
        idle(60);
        op(1'b1, A_EOM, 64'd0);
        idle(30);
        rd(A_STAT, B_DONE | B_IOVF | B_IUNF | B_OOVF, "R6 R7 status");
        rd(A_SIZE, 64'd0, "R5 count consumed");
        for (int i = 0; i < 4; i++)
            rd(A_DOUT, 64'h100 + 64'(i), "R7 kept order");
        // R8 output underflow
        rd(A_DOUT, 64'd0, "R8 empty read data");
        rd(A_STAT, B_DONE | B_IOVF | B_IUNF | B_OOVF | B_OUNF, "R8 flag");
        op(1'b1, A_STAT, '1);

        // R9 input not empty at done
        op(1'b1, A_SIZE, 64'd1);
        op(1'b1, A_DIN, 64'h11);
        op(1'b1, A_DIN, 64'h22);
        idle(10);
        op(1'b1, A_EOM, 64'd0);
        idle(15);
        rd(A_STAT, B_DONE | B_INE, "R9 residual input");
        // R10 output not empty at size write
        op(1'b1, A_SIZE, 64'd0);
        idle(2);
        rd(A_STAT, B_DONE | B_INE | B_ONE, "R10 residual output");
        rd(A_DOUT, 64'h11, "R2 job word");
        op(1'b1, A_EOM, 64'd0);
        idle(15);
        op(1'b1, A_STAT, '1);
        rd(A_STAT, 64'd0, "R13 full clear");

        // R11 address errors
        rd(3'd6, 64'd0, "R11 read offset 6 data");
        rd(A_STAT, B_ADR, "R11 read offset 6");
        op(1'b1, A_STAT, B_ADR);
        op(1'b1, A_DOUT, 64'h5);
        rd(A_STAT, B_ADR, "R11 write data-out");
        op(1'b1, A_STAT, B_ADR);
        rd(A_DIN, 64'd0, "R11 read data-in data");
        rd(A_STAT, B_ADR, "R11 read data-in");
        op(1'b1, 3'd7, 64'h1);
        rd(A_STAT, B_ADR, "R11 write offset 7");

        // R12 masking
        chk("R12 irq unmasked", {63'd0, irq}, 64'd1);
        op(1'b1, A_MASK, B_ADR);
        chk("R12 irq masked", {63'd0, irq}, 64'd0);
        rd(A_MASK, B_ADR, "R12 mask readback");
        rd(A_STAT, B_ADR, "R12 still latched");
        op(1'b1, A_MASK, 64'd0);
        chk("R12 irq unmasked again", {63'd0, irq}, 64'd1);

        // R13 selective clear
        op(1'b1, A_STAT, B_IUNF);
        rd(A_STAT, B_ADR, "R13 other bit kept");
        op(1'b1, A_STAT, B_ADR);
        rd(A_STAT, 64'd0, "R13 bit cleared");
        chk("R13 irq low", {63'd0, irq}, 64'd0);

        finish_run();
    end
endmodule